// File: doc/BRIEF.md
# Priority-Ordered Memory Protection Checker

This block guards memory accesses against a table of up to sixteen programmable protection regions. Each region is described by two configuration words: a base word, whose bit 0 marks the region as in use, and a permission word, which holds a power-of-two size exponent and a set of read, write and execute permissions kept separately for user and kernel mode. A further configuration word holds the global protection switch and the permissions of a default region that applies when no programmed region covers the address.

Every cycle the block looks at the presented access: address, write flag, execute flag and user-mode flag. It finds the enabled regions whose span contains the address and lets the one with the lowest index decide. The allow result is combinational from the access inputs. A violation flag is registered from it for accesses marked valid. When protection is switched off, every access is allowed.

Configuration is written and read back through a simple word port: a write strobe, a word offset, write data and combinational read data.

Top module: `prot_guard`

## Requirements
- R1: After synchronous active-low reset, every region is unused, protection is off, `acc_viol` is low, and every configuration offset reads back as zero.
- R2: Region n has its base word at offset 2n and its permission word at offset 2n+1. The control word sits at offset 32. A base word reads back all 32 bits. A permission word reads back bits [11:0] with the upper bits zero. The control word reads back only bit 30 and bits [8:2].
- R3: While control bit 30 is clear, `acc_allow` is 1 and `acc_viol` stays low, whatever the region table holds.
- R4: A region whose base word bit 0 is clear never matches, whatever its other fields hold.
- R5: The size exponent is e = {perm[11:9], perm[1:0]}. The region spans 2^(e+1) bytes. An address matches when its bits above bit e agree with the base word's bits above bit e. The low base bits are ignored, so alignment is not enforced.
- R6: An exponent below 10 is treated as 10, so no region is smaller than 2048 bytes.
- R7: When several enabled regions contain the address, only the lowest-indexed one decides the result.
- R8: The permission bits are: user-execute bit 3, user-write bit 4, user-read bit 5, kernel-execute bit 6, kernel-write bit 7, kernel-read bit 8. Bit 2 is reserved. `acc_user` selects the user or kernel group. `acc_exec` selects the execute bit. Otherwise `acc_write` selects the write bit, and the read bit is used when both are clear.
- R9: When protection is on and no region matches, the control word bits [8:2] decide, using the bit positions of R8.
- R10: `acc_allow` follows the access inputs in the same cycle. `acc_viol` is high in the cycle after an edge at which `acc_valid` was 1 and `acc_allow` was 0, and low otherwise.
- R11: A configuration write takes effect from the next cycle. An access in the same cycle as the write is judged on the old contents. Writes to offsets above 32 change nothing and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word offset (write and read) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | Access is a write |
| acc_exec | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access is made in user mode |
| acc_allow | output | 1 | Combinational permit for the presented access |
| acc_viol | output | 1 | Registered violation flag |

## Verification
A configuration write and an access check can fall in the same cycle. The write then changes the very region that decides the access. The bench drives both at one falling edge. It expects `acc_allow` to reflect the pre-write table in that cycle and the new table one cycle later. It also expects `acc_viol` in the next cycle to follow the old decision. Random tables with overlapping, undersized and unaligned regions are mixed with such directed cases, and every result is compared against a bench-side model of the region table.

// File: rtl/prot_guard_pkg.sv
// Package prot_guard_pkg
// Shared constants, access-kind encoding and helper functions for the
// memory protection checker. It assumes configuration words are 32 bits wide.
package prot_guard_pkg;

    localparam int CFG_W     = 32;   // configuration word width
    localparam int PERM_W    = 12;   // stored bits of a permission word
    localparam int ATTR_LO   = 2;    // lowest attribute bit position
    localparam int ATTR_W    = 7;    // attribute bits [8:2]
    localparam int ON_BIT    = 30;   // protection enable position
    localparam int MIN_EXP   = 10;   // 2^(10+1) = 2048 bytes minimum

    localparam int BIT_UX = 3;
    localparam int BIT_UW = 4;
    localparam int BIT_UR = 5;
    localparam int BIT_KX = 6;
    localparam int BIT_KW = 7;
    localparam int BIT_KR = 8;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2
    } acc_kind_e;

    // Unscrambles the size exponent and applies the minimum size.
    function automatic logic [4:0] eff_exp(input logic [PERM_W-1:0] perm);
        logic [4:0] e;
        e = {perm[11:9], perm[1:0]};
        return (e < 5'(MIN_EXP)) ? 5'(MIN_EXP) : e;
    endfunction

    // Index into the 7-bit attribute vector for an access kind and mode.
    function automatic logic [2:0] attr_index(input acc_kind_e kind,
                                              input logic user);
        int pos;
        case (kind)
            KIND_EXEC:  pos = user ? BIT_UX : BIT_KX;
            KIND_WRITE: pos = user ? BIT_UW : BIT_KW;
            default:    pos = user ? BIT_UR : BIT_KR;
        endcase
        return 3'(pos - ATTR_LO);
    endfunction

endpackage

// File: rtl/prot_guard_regfile.sv
// Module prot_guard_regfile
// Holds the region table and the control word, and decodes configuration
// writes and combinational read-back. It assumes ADDR_W <= 32 and that the
// offset port is wide enough to address 2*NUM_REGIONS+1 words.
module prot_guard_regfile
    import prot_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [OFF_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    output logic [ADDR_W-1:0]   base_q [NUM_REGIONS],
    output logic [PERM_W-1:0]   perm_q [NUM_REGIONS],
    output logic                on_q,
    output logic [ATTR_W-1:0]   dflt_q
);

    localparam int CTRL_OFF = 2 * NUM_REGIONS;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        // Captures writes to the base and permission words of region i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                perm_q[i] <= '0;
            end else if (cfg_we) begin
                if (int'(cfg_addr) == 2 * i)
                    base_q[i] <= cfg_wdata[ADDR_W-1:0];
                if (int'(cfg_addr) == 2 * i + 1)
                    perm_q[i] <= cfg_wdata[PERM_W-1:0];
            end
        end
    end

    // Captures writes to the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            dflt_q <= '0;
        end else if (cfg_we && int'(cfg_addr) == CTRL_OFF) begin
            on_q   <= cfg_wdata[ON_BIT];
            dflt_q <= cfg_wdata[ATTR_LO +: ATTR_W];
        end
    end

    // Returns the addressed word; unmapped offsets read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (int'(cfg_addr) == 2 * i)
                cfg_rdata = CFG_W'(base_q[i]);
            if (int'(cfg_addr) == 2 * i + 1)
                cfg_rdata = CFG_W'(perm_q[i]);
        end
        if (int'(cfg_addr) == CTRL_OFF) begin
            cfg_rdata[ON_BIT]              = on_q;
            cfg_rdata[ATTR_LO +: ATTR_W]   = dflt_q;
        end
    end

endmodule

// File: rtl/prot_guard_match.sv
// Module prot_guard_match
// Compares the access address against every region in parallel and returns
// one hit bit per region. It assumes the base word's bit 0 is the valid
// bit; the minimum span keeps that bit outside every compare mask.
module prot_guard_match
    import prot_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32
) (
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [ADDR_W-1:0]      base_q [NUM_REGIONS],
    input  logic [PERM_W-1:0]      perm_q [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] hit
);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
        logic [5:0]        span_lg;
        logic [ADDR_W:0]   wide_mask;
        logic [ADDR_W-1:0] keep_mask;

        // Builds the mask of address bits above the region's span.
        always_comb begin
            span_lg   = {1'b0, eff_exp(perm_q[i])} + 6'd1;
            wide_mask = {(ADDR_W+1){1'b1}} << span_lg;
            keep_mask = wide_mask[ADDR_W-1:0];
        end

        // Flags region i when it is valid and the upper bits agree.
        always_comb begin
            hit[i] = base_q[i][0] &&
                     (((acc_addr ^ base_q[i]) & keep_mask) == '0);
        end
    end

endmodule

// File: rtl/prot_guard_resolve.sv
// Module prot_guard_resolve
// Picks the lowest-indexed hit, selects its attributes (or the default
// attributes when nothing hits) and grants or denies the access. It
// assumes the hit vector is already qualified by each region's valid bit.
module prot_guard_resolve
    import prot_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16
) (
    input  logic [NUM_REGIONS-1:0] hit,
    input  logic [PERM_W-1:0]      perm_q [NUM_REGIONS],
    input  logic                   on_q,
    input  logic [ATTR_W-1:0]      dflt_q,
    input  acc_kind_e              kind,
    input  logic                   user,
    output logic [NUM_REGIONS-1:0] win,
    output logic                   allow
);

    logic [ATTR_W-1:0] win_attr;
    logic [ATTR_W-1:0] use_attr;

    // Isolates the lowest set hit bit.
    always_comb begin
        win = hit & (~hit + NUM_REGIONS'(1));
    end

    // AND-OR selection of the winning region's attributes.
    always_comb begin
        win_attr = '0;
        for (int i = 0; i < NUM_REGIONS; i++)
            win_attr |= perm_q[i][ATTR_LO +: ATTR_W] & {ATTR_W{win[i]}};
        use_attr = (hit != '0) ? win_attr : dflt_q;
    end

    // Grants when protection is off or the selected permission is set.
    always_comb begin
        allow = !on_q || use_attr[attr_index(kind, user)];
    end

endmodule

// File: rtl/prot_guard.sv
// Module prot_guard
// Top of the memory protection checker: region table, parallel matcher,
// priority resolver and registered violation flag. It assumes one access
// per cycle and that acc_exec takes precedence over acc_write.
module prot_guard
    import prot_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    localparam int OFF_W      = $clog2(2 * NUM_REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_exec,
    input  logic              acc_user,
    output logic              acc_allow,
    output logic              acc_viol
);

    logic [ADDR_W-1:0]      base_q [NUM_REGIONS];
    logic [PERM_W-1:0]      perm_q [NUM_REGIONS];
    logic                   on_q;
    logic [ATTR_W-1:0]      dflt_q;
    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] win_vec;
    logic [NUM_REGIONS-1:0] valid_vec;
    acc_kind_e              kind;

    // Encodes the access kind; a fetch outranks a write.
    always_comb begin
        if (acc_exec)       kind = KIND_EXEC;
        else if (acc_write) kind = KIND_WRITE;
        else                kind = KIND_READ;
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_valid
        assign valid_vec[i] = base_q[i][0];
    end

    prot_guard_regfile #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .base_q    (base_q),
        .perm_q    (perm_q),
        .on_q      (on_q),
        .dflt_q    (dflt_q)
    );

    prot_guard_match #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W)
    ) u_match (
        .acc_addr (acc_addr),
        .base_q   (base_q),
        .perm_q   (perm_q),
        .hit      (hit_vec)
    );

    prot_guard_resolve #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_resolve (
        .hit    (hit_vec),
        .perm_q (perm_q),
        .on_q   (on_q),
        .dflt_q (dflt_q),
        .kind   (kind),
        .user   (acc_user),
        .win    (win_vec),
        .allow  (acc_allow)
    );

    // Registers a violation for a presented access that was denied.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_viol <= 1'b0;
        else        acc_viol <= acc_valid && !acc_allow;
    end

endmodule

// File: rtl/prot_guard_chk.sv
// Module prot_guard_chk
// Property checker for prot_guard, attached through bind. It assumes the
// hit, winner and valid vectors are those of the bound instance.
module prot_guard_chk #(
    parameter int NUM_REGIONS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_valid,
    input logic                   acc_allow,
    input logic                   acc_viol,
    input logic                   prot_on,
    input logic [NUM_REGIONS-1:0] hit,
    input logic [NUM_REGIONS-1:0] win,
    input logic [NUM_REGIONS-1:0] valid_vec
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !acc_viol);

    assert_open_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_on |-> acc_allow);

    assert_invalid_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~valid_vec) == '0);

    assert_win_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));

    assert_win_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((win & hit) == win) && ((hit & (win - 1'b1)) == '0) &&
        ((hit != '0) == (win != '0)));

    assert_viol_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=> acc_viol);

    assert_viol_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_allow) |=> !acc_viol);

endmodule

bind prot_guard prot_guard_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_allow (acc_allow),
    .acc_viol  (acc_viol),
    .prot_on   (on_q),
    .hit       (hit_vec),
    .win       (win_vec),
    .valid_vec (valid_vec)
);

// File: tb/prot_guard_bench.sv
module prot_guard_bench;

    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_exec = 1'b0;
    logic        acc_user = 1'b0;
    logic        acc_allow;
    logic        acc_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side model of the configuration
    logic [31:0] m_base [NR];
    logic [11:0] m_perm [NR];
    logic        m_on;
    logic [6:0]  m_dflt;

    always #2 clk = ~clk;

    prot_guard u_prot_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_exec(acc_exec),
        .acc_user(acc_user), .acc_allow(acc_allow), .acc_viol(acc_viol)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_perm(int e, logic [6:0] attr);
        logic [4:0] ev = 5'(e);
        return {ev[4:2], attr, ev[1:0]};
    endfunction

    function automatic logic [6:0] attr_bits(int b);
        return 7'(1 << (b - 2));
    endfunction

    function automatic logic model_allow(logic [31:0] a, logic wr, logic ex, logic usr);
        logic [6:0] attr;
        logic [63:0] aa, bb;
        int e, pos;
        if (!m_on) return 1'b1;
        attr = m_dflt;
        for (int i = NR - 1; i >= 0; i--) begin
            if (m_base[i][0]) begin
                e = int'({m_perm[i][11:9], m_perm[i][1:0]});
                if (e < 10) e = 10;
                aa = {32'd0, a} >> (e + 1);
                bb = {32'd0, m_base[i]} >> (e + 1);
                if (aa == bb) attr = m_perm[i][8:2];
            end
        end
        if (ex)      pos = usr ? 3 : 6;
        else if (wr) pos = usr ? 4 : 7;
        else         pos = usr ? 5 : 8;
        return attr[pos - 2];
    endfunction

    function automatic logic [31:0] model_read(int off);
        if (off < 2 * NR) return off[0] ? {20'd0, m_perm[off/2]} : m_base[off/2];
        if (off == 2 * NR) return {1'b0, m_on, 21'd0, m_dflt, 2'b00};
        return 32'd0;
    endfunction

    task automatic model_write(int off, logic [31:0] d);
        if (off < 2 * NR) begin
            if (off[0]) m_perm[off/2] = d[11:0];
            else        m_base[off/2] = d;
        end else if (off == 2 * NR) begin
            m_on = d[30];
            m_dflt = d[8:2];
        end
    endtask

    task automatic cfg_write(int off, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(off); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(off, d);
    endtask

    task automatic cfg_read(int off, string req);
        @(negedge clk);
        cfg_addr = 6'(off);
        #1;
        chk(req, cfg_rdata, model_read(off));
    endtask

    task automatic access(logic [31:0] a, logic wr, logic ex, logic usr, string req);
        logic e;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_exec = ex; acc_user = usr;
        #1;
        e = model_allow(a, wr, ex, usr);
        chk(req, 32'(acc_allow), 32'(e));
        @(posedge clk);
        @(negedge clk);
        chk({req, " viol"}, 32'(acc_viol), 32'(!e));
        acc_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic e_old;
        for (int i = 0; i < NR; i++) begin m_base[i] = '0; m_perm[i] = '0; end
        m_on = 1'b0; m_dflt = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk("R1 viol after reset", 32'(acc_viol), 32'd0);
        cfg_read(0, "R1 base0");
        cfg_read(1, "R1 perm0");
        cfg_read(32, "R1 ctrl");
        cfg_read(31, "R1 perm15");

        // R3 protection off: deny-all region still allows
        cfg_write(0, 32'h0000_1001);
        cfg_write(1, 32'(mk_perm(10, 7'h00)));
        access(32'h0000_1200, 1'b1, 1'b0, 1'b1, "R3 off allows");

        // R7 overlap: region 0 denies, region 1 (8K at 0) allows all
        cfg_write(2, 32'h0000_0001);
        cfg_write(3, 32'(mk_perm(12, 7'h7E)));
        cfg_write(32, 32'h4000_0000);
        access(32'h0000_1200, 1'b0, 1'b0, 1'b1, "R7 lower index denies");
        access(32'h0000_1900, 1'b0, 1'b0, 1'b1, "R5 outside region0 span");
        access(32'h0000_2000, 1'b0, 1'b0, 1'b0, "R5 beyond region1 span");

        // R4 invalid region ignored
        cfg_write(0, 32'h0000_1000);
        access(32'h0000_1200, 1'b1, 1'b0, 1'b1, "R4 invalid region skipped");

        // R6 undersized exponent clamped to 2048 bytes
        cfg_write(4, 32'h0000_4001);
        cfg_write(5, 32'(mk_perm(2, attr_bits(5))));
        access(32'h0000_47FF, 1'b0, 1'b0, 1'b1, "R6 inside min span");
        access(32'h0000_4800, 1'b0, 1'b0, 1'b1, "R6 past min span");

        // R5 unaligned base: low base bits ignored
        cfg_write(6, 32'h0000_8123 | 32'h1);
        cfg_write(7, 32'(mk_perm(10, attr_bits(7))));
        access(32'h0000_8004, 1'b1, 1'b0, 1'b0, "R5 unaligned base kernel write");

        // R8 individual permission bits: kernel execute only
        cfg_write(8, 32'h0000_C001);
        cfg_write(9, 32'(mk_perm(10, attr_bits(6))));
        access(32'h0000_C010, 1'b0, 1'b1, 1'b0, "R8 kernel exec");
        access(32'h0000_C010, 1'b0, 1'b0, 1'b0, "R8 kernel read");
        access(32'h0000_C010, 1'b0, 1'b1, 1'b1, "R8 user exec");
        access(32'h0000_C010, 1'b1, 1'b1, 1'b0, "R8 exec outranks write");

        // R9 default attributes: user read only
        cfg_write(32, 32'h4000_0000 | 32'(attr_bits(5)) << 2);
        access(32'h0003_0000, 1'b0, 1'b0, 1'b1, "R9 default user read");
        access(32'h0003_0000, 1'b1, 1'b0, 1'b1, "R9 default user write");

        // R2 read-back masking
        cfg_write(11, 32'hFFFF_FFFF);
        cfg_read(11, "R2 perm readback");
        cfg_write(32, 32'hFFFF_FFFF);
        cfg_read(32, "R2 ctrl readback");
        cfg_write(10, 32'hDEAD_BEEE);
        cfg_read(10, "R2 base readback");

        // R11 unmapped offsets ignored
        cfg_write(40, 32'hFFFF_FFFF);
        cfg_read(40, "R11 unmapped reads zero");
        cfg_read(2, "R11 region1 base unchanged");
        cfg_read(32, "R11 ctrl unchanged");
        access(32'h0000_1200, 1'b1, 1'b0, 1'b1, "R11 behaviour unchanged");

        // R11 write and access in the same cycle
        cfg_write(32, 32'h4000_0000);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h0000_1200; acc_write = 1'b0;
        acc_exec = 1'b0; acc_user = 1'b1;
        cfg_we = 1'b1; cfg_addr = 6'd2; cfg_wdata = 32'h0000_0000;
        #1;
        e_old = model_allow(32'h0000_1200, 1'b0, 1'b0, 1'b1);
        chk("R11 same-cycle uses old table", 32'(acc_allow), 32'(e_old));
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(2, 32'h0000_0000);
        chk("R11 viol from old decision", 32'(acc_viol), 32'(!e_old));
        chk("R11 new table next cycle", 32'(acc_allow),
            32'(model_allow(32'h0000_1200, 1'b0, 1'b0, 1'b1)));
        acc_valid = 1'b0;

        // random tables with overlapping, undersized and unaligned regions
        for (int round = 0; round < 4; round++) begin
            for (int i = 0; i < NR; i++) begin
                logic [31:0] b = $urandom & 32'h0001_FFFF;
                b[0] = ($urandom_range(3) != 0);
                cfg_write(2 * i, b);
                cfg_write(2 * i + 1, $urandom & 32'h0000_0FFF);
            end
            cfg_write(32, {1'b0, (round != 3), 21'd0, 7'($urandom), 2'b00});
            for (int k = 0; k < 120; k++) begin
                logic [2:0] f = 3'($urandom);
                access($urandom & 32'h0003_FFFF, f[0], f[1], f[2],
                       "R7 random priority check");
            end
        end

        finish_run();
    end

endmodule